// File: doc/BRIEF.md
# Pin Controller with Shared Timer I/O

This block sits between a set of general-purpose pads and the logic that uses them. Each pin has one 8-bit configuration register, written and read over a small address/data bus. From that register and a firmware data bit, the block decides what each pad drives and whether the pad is driven at all. The choices are a firmware-held level, a timer tick, or open-drain low-only drive. Pull-up and input-threshold selections leave the block as plain control lines for the pad cells.

The first `NUM_SHARED` pins double as timer I/O. With the output enable clear, the synchronized pad level feeds that pin's timer capture input. With both the output enable and the timer-drive bit set, the pad carries the timer's one-cycle tick outward. With only the output enable set, the firmware data bit drives the pad, and the same bit goes back into the capture input. Two further pins follow the shared ones:

- a plain pin with no timer function;
- an open-drain-only pin that can only pull low. Its pull-up bit is wired to the pull-ups of two pads at once.

Every pin also latches an interrupt when its synchronized input moves into a selectable active level. Each latched interrupt stays set until a clear strobe removes it.

Top module: `gio_pin_ctrl`

## Requirements
- R1: After reset, every configuration register reads 0, and all of `pad_oe`, `pad_pu`, `pad_ttl` and `irq` are 0.
- R2: Pin k's register sits at address `BASE_ADDR + k`. With the defaults, the shared pins are at 0x0A and 0x0B, the plain pin at 0x0C and the open-drain-only pin at 0x0D. Reads of any other address return 0.
- R3: Bit fields: bit 0 output enable, bit 1 pull-up, bit 2 open drain, bit 4 TTL threshold, bit 5 interrupt active-low, bit 6 interrupt enable, bit 7 timer drive. The following bits are reserved, read 0 and ignore writes:
  - bit 3 on every pin;
  - bit 7 on the plain pin;
  - bits 7, 4, 3 and 2 on the open-drain-only pin.
- R4: With bit 0 clear, `pad_oe` is 0. A shared pin's `cap_in` then follows its `pad_in`, two clock edges after `pad_in` changes.
- R5: On a shared pin with bit 0 set and bit 7 clear, `pad_out` equals the pin's `port_data` bit and `cap_in` shows that same bit in the same cycle.
- R6: On a shared pin with bits 0 and 7 both set, `pad_out` follows `tick_in` in the same cycle, whatever the value of bit 6, and `cap_in` is 0.
- R7: On a pin with bit 2 set, `pad_oe` is high only while the selected output value is 0. Otherwise the pad is released.
- R8: The open-drain-only pin always has `pad_out` = 0, and `pad_oe` = bit 0 AND NOT `port_data`.
- R9: `pad_pu` mirrors bit 1 and `pad_ttl` mirrors bit 4, in input, data and timer modes alike.
- R10: With bit 6 set, a synchronized input transition into the active level latches `irq`. The active level is high when bit 5 is 0 and low when bit 5 is 1. `irq` rises on the third clock edge after `pad_in` changes. Changing the polarity alone does not raise `irq`.
- R11: With bit 6 clear, input transitions never raise `irq`. A one-cycle `irq_clr` strobe clears a latched `irq` at the next edge, unless a new event arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| port_data | input | NPIN | Firmware data bit per pin |
| tick_in | input | NUM_SHARED | One-cycle timer ticks, one per shared pin |
| pad_in | input | NPIN | Raw pad levels |
| pad_out | output | NPIN | Pad output value |
| pad_oe | output | NPIN | Pad driver enable |
| pad_pu | output | NPIN | Pull-up control (the last bit serves two pads) |
| pad_ttl | output | NPIN | Input threshold select |
| cap_in | output | NUM_SHARED | Timer capture inputs |
| irq_clr | input | NPIN | Clear strobe for latched interrupts |
| irq | output | NPIN | Latched pin interrupts |

## Verification
On every cycle, the assertions check four things:

- a pin with output enable clear never drives;
- an open-drain pin drives only a low value;
- the tick passes straight through in timer mode;
- every rising `irq` follows a qualified input event, and every clear strobe takes effect.

Only the bench's scenarios can show the rest:

- the exact synchronizer latency;
- the reserved-bit masking at each address;
- the write-to-readback path;
- that a polarity change alone stays silent.

// File: rtl/gio_pkg.sv
package gio_pkg;

  typedef enum logic [1:0] {
    PK_SHARED = 2'd0,
    PK_PLAIN  = 2'd1,
    PK_ODONLY = 2'd2
  } pin_kind_e;

  localparam int B_OE   = 0;
  localparam int B_PU   = 1;
  localparam int B_OD   = 2;
  localparam int B_TTL  = 4;
  localparam int B_ILOW = 5;
  localparam int B_IEN  = 6;
  localparam int B_TIO  = 7;

  // Pins [0, nsh) are timer-shared, then one plain pin, then the open-drain-only pin.
  function automatic pin_kind_e kind_of(input int idx, input int nsh);
    if (idx < nsh)       return PK_SHARED;
    else if (idx == nsh) return PK_PLAIN;
    else                 return PK_ODONLY;
  endfunction

  // Writable bits per kind.
  function automatic logic [7:0] cfg_mask(input pin_kind_e k);
    case (k)
      PK_SHARED: return 8'hF7;
      PK_PLAIN:  return 8'h77;
      default:   return 8'h63;
    endcase
  endfunction

  // Value presented on a shared pad.
  function automatic logic drive_val(input logic [7:0] cfg, input logic data, input logic tick);
    return (cfg[B_TIO] && cfg[B_OE]) ? tick : data;
  endfunction

  // Driver enable, honouring open-drain release on a high value.
  function automatic logic drive_en(input logic [7:0] cfg, input logic val);
    return cfg[B_OE] && (!cfg[B_OD] || !val);
  endfunction

  // What the timer capture input sees.
  function automatic logic cap_val(input logic [7:0] cfg, input logic data, input logic lvl);
    if (!cfg[B_OE])  return lvl;
    if (cfg[B_TIO])  return 1'b0;
    return data;
  endfunction

  // Entry into the active level; polarity applied to both samples.
  function automatic logic edge_hit(input logic s, input logic s_prev, input logic act_low);
    return (s ^ act_low) && !(s_prev ^ act_low);
  endfunction

endpackage

// File: rtl/gio_cfg_regs.sv
module gio_cfg_regs #(
  parameter int NPIN       = 4,
  parameter int NUM_SHARED = 2,
  parameter int ADDR_W     = 8,
  parameter int BASE_ADDR  = 'h0A
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wr,
  input  logic [7:0]                wdata,
  output logic [NPIN-1:0][7:0]      cfg
);
  for (genvar g = 0; g < NPIN; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + g);
    localparam logic [7:0]        MASK    = gio_pkg::cfg_mask(gio_pkg::kind_of(g, NUM_SHARED));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cfg[g] <= '0;
      else if (wr && addr == MY_ADDR) cfg[g] <= wdata & MASK;
    end
  end
endmodule

// File: rtl/gio_in_sync.sv
module gio_in_sync #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] lvl,
  output logic [NPIN-1:0] lvl_prev
);
  logic [NPIN-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta     <= '0;
      lvl      <= '0;
      lvl_prev <= '0;
    end else begin
      meta     <= pad_in;
      lvl      <= meta;
      lvl_prev <= lvl;
    end
  end
endmodule

// File: rtl/gio_irq_latch.sv
module gio_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic lvl_prev,
  input  logic act_low,
  input  logic enable,
  input  logic clr,
  output logic hit,
  output logic irq
);
  assign hit = enable && gio_pkg::edge_hit(lvl, lvl_prev, act_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq <= 1'b0;
    else if (hit) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end
endmodule

// File: rtl/gio_pin_ctrl.sv
module gio_pin_ctrl #(
  parameter int NUM_SHARED = 2,
  parameter int ADDR_W     = 8,
  parameter int BASE_ADDR  = 'h0A,
  localparam int NPIN      = NUM_SHARED + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic [NPIN-1:0]       port_data,
  input  logic [NUM_SHARED-1:0] tick_in,
  input  logic [NPIN-1:0]       pad_in,
  output logic [NPIN-1:0]       pad_out,
  output logic [NPIN-1:0]       pad_oe,
  output logic [NPIN-1:0]       pad_pu,
  output logic [NPIN-1:0]       pad_ttl,
  output logic [NUM_SHARED-1:0] cap_in,
  input  logic [NPIN-1:0]       irq_clr,
  output logic [NPIN-1:0]       irq
);
  import gio_pkg::*;

  logic [NPIN-1:0][7:0] cfg_w;
  logic [NPIN-1:0]      lvl_w, lvl_prev_w;
  logic [NPIN-1:0]      irq_hit;
  logic [NPIN-1:0]      cfg_oe, cfg_od, cfg_tio, cfg_ien;

  gio_cfg_regs #(
    .NPIN(NPIN), .NUM_SHARED(NUM_SHARED), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata), .cfg(cfg_w)
  );

  gio_in_sync #(.NPIN(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .lvl(lvl_w), .lvl_prev(lvl_prev_w)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NPIN; i++)
      if (bus_addr == ADDR_W'(BASE_ADDR + i)) bus_rdata = cfg_w[i];
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    localparam pin_kind_e KIND = kind_of(g, NUM_SHARED);

    assign cfg_oe[g]  = cfg_w[g][B_OE];
    assign cfg_od[g]  = cfg_w[g][B_OD];
    assign cfg_tio[g] = cfg_w[g][B_TIO];
    assign cfg_ien[g] = cfg_w[g][B_IEN];
    assign pad_pu[g]  = cfg_w[g][B_PU];

    if (KIND == PK_SHARED) begin : g_shared
      logic val;
      assign val       = drive_val(cfg_w[g], port_data[g], tick_in[g]);
      assign pad_out[g] = val;
      assign pad_oe[g]  = drive_en(cfg_w[g], val);
      assign pad_ttl[g] = cfg_w[g][B_TTL];
      assign cap_in[g]  = cap_val(cfg_w[g], port_data[g], lvl_w[g]);
    end else if (KIND == PK_PLAIN) begin : g_plain
      assign pad_out[g] = port_data[g];
      assign pad_oe[g]  = drive_en(cfg_w[g], port_data[g]);
      assign pad_ttl[g] = cfg_w[g][B_TTL];
    end else begin : g_odonly
      assign pad_out[g] = 1'b0;
      assign pad_oe[g]  = cfg_w[g][B_OE] && !port_data[g];
      assign pad_ttl[g] = 1'b0;
    end

    gio_irq_latch u_irq (
      .clk(clk), .rst_n(rst_n),
      .lvl(lvl_w[g]), .lvl_prev(lvl_prev_w[g]),
      .act_low(cfg_w[g][B_ILOW]), .enable(cfg_w[g][B_IEN]),
      .clr(irq_clr[g]), .hit(irq_hit[g]), .irq(irq[g])
    );
  end
endmodule

// File: rtl/gio_pin_ctrl_chk.sv
module gio_pin_ctrl_chk #(
  parameter int NPIN       = 4,
  parameter int NUM_SHARED = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NPIN-1:0]       cfg_oe,
  input logic [NPIN-1:0]       cfg_od,
  input logic [NPIN-1:0]       cfg_tio,
  input logic [NPIN-1:0]       cfg_ien,
  input logic [NPIN-1:0]       pad_out,
  input logic [NPIN-1:0]       pad_oe,
  input logic [NUM_SHARED-1:0] tick_in,
  input logic [NPIN-1:0]       irq_hit,
  input logic [NPIN-1:0]       irq_clr,
  input logic [NPIN-1:0]       irq
);
  for (genvar i = 0; i < NPIN; i++) begin : g_chk
    localparam bit ODONLY = (i == NPIN - 1);

    AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_oe[i] |-> !pad_oe[i]); // R4

    AST_OPEN_DRAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe[i] && (cfg_od[i] || ODONLY)) |-> !pad_out[i]); // R7

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> ($past(irq_hit[i]) && $past(cfg_ien[i]))); // R10

    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(irq_clr[i] && !irq_hit[i]) |-> !irq[i]); // R11

    if (i < NUM_SHARED) begin : g_tick
      AST_TICK_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tio[i] && cfg_oe[i]) |-> (pad_out[i] == tick_in[i])); // R6
    end
  end
endmodule

bind gio_pin_ctrl gio_pin_ctrl_chk #(.NPIN(NPIN), .NUM_SHARED(NUM_SHARED)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_oe(cfg_oe), .cfg_od(cfg_od), .cfg_tio(cfg_tio),
  .cfg_ien(cfg_ien), .pad_out(pad_out), .pad_oe(pad_oe), .tick_in(tick_in),
  .irq_hit(irq_hit), .irq_clr(irq_clr), .irq(irq)
);

// File: tb/tb_gio_pin_ctrl.sv
module tb_gio_pin_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSH  = 2;
  localparam int NP   = NSH + 2;
  localparam int BASE = 'h0A;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NP-1:0] port_data = '0;
  logic [NSH-1:0] tick_in = '0;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_pu, pad_ttl, irq;
  logic [NSH-1:0] cap_in;
  logic [NP-1:0] irq_clr = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gio_pin_ctrl #(.NUM_SHARED(NSH), .ADDR_W(8), .BASE_ADDR(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_data(port_data),
    .tick_in(tick_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_ttl(pad_ttl), .cap_in(cap_in), .irq_clr(irq_clr), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int pin, input logic [7:0] v);
    @(negedge clk);
    bus_addr = 8'(BASE + pin); bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic clear_all();
    for (int p = 0; p < NP; p++) wr_reg(p, 8'h00);
    port_data = '0; tick_in = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int p = 0; p < NP; p++) begin
      rd_reg(8'(BASE + p), v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 reset pad_oe", pad_oe, 0);
    chk("R1 reset pad_pu", pad_pu, 0);
    chk("R1 reset pad_ttl", pad_ttl, 0);
    chk("R1 reset irq", irq, 0);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    for (int p = 0; p < NP; p++) wr_reg(p, 8'hFF);
    rd_reg(8'h0A, v); chk("R3 shared0 mask", v, 8'hF7);
    rd_reg(8'h0B, v); chk("R3 shared1 mask", v, 8'hF7);
    rd_reg(8'h0C, v); chk("R3 plain mask", v, 8'h77);
    rd_reg(8'h0D, v); chk("R3 odonly mask", v, 8'h63);
    rd_reg(8'h09, v); chk("R2 unmapped low", v, 0);
    rd_reg(8'h0E, v); chk("R2 unmapped high", v, 0);
    wr_reg(1, 8'h5A);
    rd_reg(8'h0B, v); chk("R2 write reaches 0x0B only", v, 8'h52);
    rd_reg(8'h0A, v); chk("R2 0x0A untouched", v, 8'hF7);
    clear_all();
  endtask

  task automatic t_input_cap();
    wr_reg(0, 8'h00);
    @(negedge clk); pad_in[0] = 1'b1;
    @(negedge clk); chk("R4 cap before sync", cap_in[0], 0);
    @(negedge clk); chk("R4 cap after two edges", cap_in[0], 1);
    chk("R4 input not driven", pad_oe[0], 0);
    pad_in[0] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 cap follows low", cap_in[0], 0);
  endtask

  task automatic t_gpio_out();
    wr_reg(0, 8'h01);
    pad_in[0] = 1'b1; port_data[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 cap sees data not pad", cap_in[0], 0);
    chk("R5 pad_out data 0", pad_out[0], 0);
    port_data[0] = 1'b1; #1;
    chk("R5 pad_out data 1", pad_out[0], 1);
    chk("R5 pad driven", pad_oe[0], 1);
    chk("R5 cap same cycle", cap_in[0], 1);
    pad_in[0] = 1'b0;
    clear_all();
  endtask

  task automatic t_timer_out();
    wr_reg(1, 8'h81);
    port_data[1] = 1'b1; tick_in[1] = 1'b0; #1;
    chk("R6 tick low ignores data", pad_out[1], 0);
    chk("R6 capture idle", cap_in[1], 0);
    tick_in[1] = 1'b1; #1;
    chk("R6 tick passes through", pad_out[1], 1);
    chk("R6 driven in timer mode", pad_oe[1], 1);
    @(negedge clk); tick_in[1] = 1'b0; #1;
    chk("R6 tick one cycle", pad_out[1], 0);
    clear_all();
  endtask

  task automatic t_open_drain();
    wr_reg(2, 8'h05);
    port_data[2] = 1'b1; #1;
    chk("R7 high released", pad_oe[2], 0);
    port_data[2] = 1'b0; #1;
    chk("R7 low driven", pad_oe[2], 1);
    chk("R7 low value", pad_out[2], 0);
    wr_reg(0, 8'h85); tick_in[0] = 1'b1; #1;
    chk("R7 tick high released", pad_oe[0], 0);
    tick_in[0] = 1'b0; #1;
    chk("R7 tick low driven", pad_oe[0], 1);
    clear_all();
  endtask

  task automatic t_od_pin();
    wr_reg(3, 8'h01);
    port_data[3] = 1'b1; #1;
    chk("R8 odonly high released", pad_oe[3], 0);
    port_data[3] = 1'b0; #1;
    chk("R8 odonly low driven", pad_oe[3], 1);
    chk("R8 odonly out zero", pad_out[3], 0);
    wr_reg(3, 8'h00); #1;
    chk("R8 odonly disabled", pad_oe[3], 0);
    clear_all();
  endtask

  task automatic t_passthru();
    wr_reg(0, 8'h92); wr_reg(1, 8'h13); wr_reg(3, 8'h02); #1;
    chk("R9 pu input mode", pad_pu[0], 1);
    chk("R9 ttl input mode", pad_ttl[0], 1);
    chk("R9 pu data mode", pad_pu[1], 1);
    chk("R9 ttl data mode", pad_ttl[1], 1);
    chk("R9 odonly pair pull-up", pad_pu[3], 1);
    chk("R9 odonly no ttl", pad_ttl[3], 0);
    clear_all();
  endtask

  task automatic pulse_clr(input int p);
    @(negedge clk); irq_clr[p] = 1'b1;
    @(negedge clk); irq_clr[p] = 1'b0;
  endtask

  task automatic t_irq();
    wr_reg(2, 8'h40);
    pad_in[2] = 1'b0;
    repeat (4) @(negedge clk);
    pad_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 irq not before third edge", irq[2], 0);
    @(negedge clk);
    chk("R10 irq on rising entry", irq[2], 1);
    pulse_clr(2);
    chk("R11 irq cleared", irq[2], 0);
    wr_reg(2, 8'h60);
    repeat (3) @(negedge clk);
    chk("R10 polarity change alone silent", irq[2], 0);
    pad_in[2] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 irq on falling entry", irq[2], 1);
    pulse_clr(2);
    clear_all();
  endtask

  task automatic t_irq_disabled();
    wr_reg(2, 8'h20);
    pad_in[2] = 1'b1;
    repeat (4) @(negedge clk);
    pad_in[2] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 disabled no irq", irq, 0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_regmap();
    t_input_cap();
    t_gpio_out();
    t_timer_out();
    t_open_drain();
    t_od_pin();
    t_passthru();
    t_irq();
    t_irq_disabled();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule